// File: doc/BRIEF.md
# PCIe Completion Header Checker

This block classifies every completion header arriving from the link against the stored record of the outstanding request that shares its tag. The surrounding logic looks up the request table and presents, in the same cycle, the parsed completion fields together with the matching table entry. The entry holds a valid flag, the request kind, the requester ID, the full tag, the requested length, and the expected byte count and lower address. The checker returns one verdict per completion: good, unsolicited, malformed, configuration retry, unsuccessful read or unsuccessful write.

The verdict comes from an ordered list of rules, and the first rule that matches decides the result. From the verdict the block derives four things: an error vector, a forward/drop decision, a strobe that tells the table to release the entry, and a request to cancel the completion timer of that tag. Three control inputs relax individual rules. One of them also turns on an alternate mode in which unsuccessful completions release their entry. The block has a single registered stage and accepts one header on every cycle that `in_valid` is high, with no stall.

Top module: `cmpl_hdr_checker`

## Requirements
- R1: A verdict appears on the outputs exactly one clock after each cycle with `in_valid` high: `out_valid` is 1 and `out_tag` repeats that cycle's `cpl_tag`. After a cycle with `in_valid` low, all outputs are 0. The 6-bit `out_err` is all zeros for a good completion. Otherwise exactly one bit is set: bit 1 retry, bit 2 malformed, bit 3 unsolicited, bit 4 unsuccessful read, bit 5 unsuccessful write. Bit 0 is never set. All outputs are 0 while `rst` is high.
- R2: The completion is unsolicited when any of the following holds: `ent_valid` is 0, the requester IDs differ, the full tags differ, or the completion is a locked type. In `cpl_type`, bit 0 = carries data and bit 1 = locked. Request kinds in `ent_kind` are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 configuration read, 5 configuration write. Status codes are 0 successful, 1 unsupported request, 2 configuration retry, 4 completer abort, and any other value is reserved.
- R3: A completion is malformed in three cases: it carries data and its status is neither 0 nor 2; it carries data and answers a write kind (1, 3 or 5); or it has no data, status 0 and answers a read kind (0, 2 or 4).
- R4: A nonzero traffic class or nonzero attributes mark the completion malformed. So does a data completion whose length differs from `ent_len`.
- R5: Unless `skip_bcnt` is 1, the byte count must equal 4 for I/O and configuration kinds and must equal `ent_bcnt` for a memory read. A mismatch is malformed.
- R6: Unless `skip_laddr` is 1, the lower address must be 0 for I/O and configuration kinds and must equal `ent_laddr` for a memory read. A mismatch is malformed.
- R7: Status 2 on a configuration kind gives the retry error. Status 2 on any other kind is malformed while `relax_crs` is 0.
- R8: With `relax_crs` at 0, the unsuccessful errors are raised as follows. Status 4 on a read kind gives unsuccessful read. Status 4 on an I/O or configuration write gives unsuccessful write. Status 1 or a reserved status gives unsuccessful write on an I/O or configuration write, and unsuccessful read on a read kind. None of these releases the entry.
- R9: With `relax_crs` at 1, any nonzero status that reaches this stage gives unsuccessful read on a read kind, or unsuccessful write on any write kind, and the entry is released.
- R10: `out_free` is 1 for a good verdict and for the alternate-mode unsuccessful verdicts of R9. It is 0 for every other verdict.
- R11: `out_forward` is 1 only for good, unsuccessful-read and unsuccessful-write verdicts. `out_cancel` is 1 exactly for malformed and retry verdicts.
- R12: The rules are applied in the order R2, R3/R4 (length last), R7 malformed case, R5, R6, R7 retry, R9, R8, and the first match decides the verdict. The R7 malformed case is checked before any write-kind test, and any condition that R2 matches overrides all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A completion header is presented this cycle |
| cpl_type | input | 2 | Bit 0 carries data, bit 1 locked |
| cpl_status | input | 3 | Completion status |
| cpl_req_id | input | 16 | Requester ID in the completion |
| cpl_tag | input | 8 | Tag in the completion |
| cpl_tc | input | 3 | Traffic class |
| cpl_attr | input | 2 | Attributes |
| cpl_len | input | 10 | Length in dwords |
| cpl_bcnt | input | 12 | Byte count |
| cpl_laddr | input | 7 | Lower address |
| ent_valid | input | 1 | Table entry is outstanding |
| ent_kind | input | 3 | Stored request kind |
| ent_req_id | input | 16 | Stored requester ID |
| ent_tag | input | 8 | Stored full tag |
| ent_len | input | 10 | Stored requested length |
| ent_bcnt | input | 12 | Expected byte count for memory reads |
| ent_laddr | input | 7 | Expected lower address for memory reads |
| relax_crs | input | 1 | Skip retry-on-non-configuration rule; alternate unsuccessful handling |
| skip_bcnt | input | 1 | Skip the byte count rule |
| skip_laddr | input | 1 | Skip the lower address rule |
| out_valid | output | 1 | Verdict valid |
| out_err | output | 6 | Error vector |
| out_forward | output | 1 | Forward the completion |
| out_free | output | 1 | Release the table entry |
| out_cancel | output | 1 | Cancel the timer of `out_tag` |
| out_tag | output | 8 | Tag the verdict belongs to |

## Verification
On every cycle, the assertions check the one-cycle timing of the verdict and the echoed tag. They also check that the outputs stay quiet after idle cycles, that unsolicited and locked completions are always dropped without release, and that at most one error bit is set. The consistency among error, forward, cancel and release is checked on every cycle as well. The rule order itself can only be shown by the bench's scenarios, which is where conditions overlap. Examples are a retry status on a write with data, a length mismatch together with a bad byte count, and the alternate mode changing both the verdict and the release. To cover these, the bench sweeps every request kind, completion type, status code and control-bit combination against a set of single-field corruptions.

// File: rtl/cplchk_pkg.sv
package cplchk_pkg;

  localparam int NUM_RULES = 16;
  localparam int ERR_W     = 6;

  localparam logic [2:0] RQ_MRD   = 3'd0;
  localparam logic [2:0] RQ_MWR   = 3'd1;
  localparam logic [2:0] RQ_IORD  = 3'd2;
  localparam logic [2:0] RQ_IOWR  = 3'd3;
  localparam logic [2:0] RQ_CFGRD = 3'd4;
  localparam logic [2:0] RQ_CFGWR = 3'd5;

  localparam logic [2:0] ST_OK  = 3'd0;
  localparam logic [2:0] ST_UR  = 3'd1;
  localparam logic [2:0] ST_CRS = 3'd2;
  localparam logic [2:0] ST_CA  = 3'd4;

  // Verdict values equal the error vector bit they raise.
  typedef enum logic [2:0] {
    VD_GOOD   = 3'd0,
    VD_RETRY  = 3'd1,
    VD_MALF   = 3'd2,
    VD_UNSOL  = 3'd3,
    VD_RDFAIL = 3'd4,
    VD_WRFAIL = 3'd5
  } verdict_e;

  // Rule index -> verdict, in priority order (index 0 wins).
  function automatic verdict_e rule_verdict(input int idx);
    verdict_e v;
    case (idx)
      0:                      v = VD_UNSOL;
      1, 2, 3, 4, 5, 6, 7, 8: v = VD_MALF;
      9:                      v = VD_RETRY;
      10, 12, 15:             v = VD_RDFAIL;
      11, 13, 14:             v = VD_WRFAIL;
      default:                v = VD_GOOD;
    endcase
    return v;
  endfunction

  // Rules whose hit releases the entry (alternate-mode failures).
  function automatic logic rule_frees(input int idx);
    return (idx == 10) || (idx == 11);
  endfunction

  function automatic logic kind_is_read(input logic [2:0] k);
    return (k == RQ_MRD) || (k == RQ_IORD) || (k == RQ_CFGRD);
  endfunction

  function automatic logic kind_is_write(input logic [2:0] k);
    return (k == RQ_MWR) || (k == RQ_IOWR) || (k == RQ_CFGWR);
  endfunction

  function automatic logic kind_is_cfg(input logic [2:0] k);
    return (k == RQ_CFGRD) || (k == RQ_CFGWR);
  endfunction

  function automatic logic kind_is_iocfg(input logic [2:0] k);
    return (k == RQ_IORD) || (k == RQ_IOWR) || kind_is_cfg(k);
  endfunction

endpackage

// File: rtl/cplchk_rules.sv
module cplchk_rules
  import cplchk_pkg::*;
#(
  parameter int RID_W   = 16,
  parameter int TAG_W   = 8,
  parameter int TC_W    = 3,
  parameter int ATTR_W  = 2,
  parameter int LEN_W   = 10,
  parameter int BCNT_W  = 12,
  parameter int LADDR_W = 7,
  parameter int IO_BCNT = 4
) (
  input  logic [1:0]           cpl_type,
  input  logic [2:0]           cpl_status,
  input  logic [RID_W-1:0]     cpl_req_id,
  input  logic [TAG_W-1:0]     cpl_tag,
  input  logic [TC_W-1:0]      cpl_tc,
  input  logic [ATTR_W-1:0]    cpl_attr,
  input  logic [LEN_W-1:0]     cpl_len,
  input  logic [BCNT_W-1:0]    cpl_bcnt,
  input  logic [LADDR_W-1:0]   cpl_laddr,
  input  logic                 ent_valid,
  input  logic [2:0]           ent_kind,
  input  logic [RID_W-1:0]     ent_req_id,
  input  logic [TAG_W-1:0]     ent_tag,
  input  logic [LEN_W-1:0]     ent_len,
  input  logic [BCNT_W-1:0]    ent_bcnt,
  input  logic [LADDR_W-1:0]   ent_laddr,
  input  logic                 relax_crs,
  input  logic                 skip_bcnt,
  input  logic                 skip_laddr,
  output logic [NUM_RULES-1:0] hit
);

  localparam logic [BCNT_W-1:0] IO_BCNT_V = BCNT_W'(IO_BCNT);

  logic has_data, locked;
  logic k_rd, k_wr, k_cfg, k_iocfg, k_iocfg_wr, k_mrd;
  logic s_ok, s_crs, s_ca, s_ur_or_rsvd;
  logic bcnt_bad, laddr_bad;

  always_comb begin
    has_data     = cpl_type[0];
    locked       = cpl_type[1];
    k_rd         = kind_is_read(ent_kind);
    k_wr         = kind_is_write(ent_kind);
    k_cfg        = kind_is_cfg(ent_kind);
    k_iocfg      = kind_is_iocfg(ent_kind);
    k_iocfg_wr   = k_iocfg && k_wr;
    k_mrd        = (ent_kind == RQ_MRD);
    s_ok         = (cpl_status == ST_OK);
    s_crs        = (cpl_status == ST_CRS);
    s_ca         = (cpl_status == ST_CA);
    s_ur_or_rsvd = !s_ok && !s_crs && !s_ca;

    bcnt_bad  = (k_iocfg && (cpl_bcnt != IO_BCNT_V)) ||
                (k_mrd && (cpl_bcnt != ent_bcnt));
    laddr_bad = (k_iocfg && (cpl_laddr != '0)) ||
                (k_mrd && (cpl_laddr != ent_laddr));
  end

  always_comb begin
    hit     = '0;
    // identity
    hit[0]  = !ent_valid || (cpl_req_id != ent_req_id) ||
              (cpl_tag != ent_tag) || locked;
    // format and content
    hit[1]  = has_data && !s_ok && !s_crs;
    hit[2]  = !relax_crs && s_crs && !k_cfg;
    hit[3]  = has_data && k_wr;
    hit[4]  = !has_data && s_ok && k_rd;
    hit[5]  = (cpl_tc != '0) || (cpl_attr != '0);
    hit[6]  = has_data && (cpl_len != ent_len);
    hit[7]  = !skip_bcnt && bcnt_bad;
    hit[8]  = !skip_laddr && laddr_bad;
    // status outcomes
    hit[9]  = s_crs && k_cfg;
    hit[10] = relax_crs && !s_ok && k_rd;
    hit[11] = relax_crs && !s_ok && k_wr;
    hit[12] = s_ca && k_rd;
    hit[13] = s_ca && k_iocfg_wr;
    hit[14] = s_ur_or_rsvd && k_iocfg_wr;
    hit[15] = s_ur_or_rsvd && k_rd;
  end

endmodule

// File: rtl/cplchk_arbiter.sv
module cplchk_arbiter #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);

  logic [N-1:0] seen;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pri
      if (i == 0) begin : g_first
        assign grant[i] = req[i];
        assign seen[i]  = req[i];
      end else begin : g_rest
        assign grant[i] = req[i] && !seen[i-1];
        assign seen[i]  = req[i] || seen[i-1];
      end
    end
  endgenerate

  assign any = seen[N-1];

endmodule

// File: rtl/cmpl_hdr_checker.sv
module cmpl_hdr_checker
  import cplchk_pkg::*;
#(
  parameter int RID_W   = 16,
  parameter int TAG_W   = 8,
  parameter int TC_W    = 3,
  parameter int ATTR_W  = 2,
  parameter int LEN_W   = 10,
  parameter int BCNT_W  = 12,
  parameter int LADDR_W = 7,
  parameter int IO_BCNT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         cpl_type,
  input  logic [2:0]         cpl_status,
  input  logic [RID_W-1:0]   cpl_req_id,
  input  logic [TAG_W-1:0]   cpl_tag,
  input  logic [TC_W-1:0]    cpl_tc,
  input  logic [ATTR_W-1:0]  cpl_attr,
  input  logic [LEN_W-1:0]   cpl_len,
  input  logic [BCNT_W-1:0]  cpl_bcnt,
  input  logic [LADDR_W-1:0] cpl_laddr,
  input  logic               ent_valid,
  input  logic [2:0]         ent_kind,
  input  logic [RID_W-1:0]   ent_req_id,
  input  logic [TAG_W-1:0]   ent_tag,
  input  logic [LEN_W-1:0]   ent_len,
  input  logic [BCNT_W-1:0]  ent_bcnt,
  input  logic [LADDR_W-1:0] ent_laddr,
  input  logic               relax_crs,
  input  logic               skip_bcnt,
  input  logic               skip_laddr,
  output logic               out_valid,
  output logic [ERR_W-1:0]   out_err,
  output logic               out_forward,
  output logic               out_free,
  output logic               out_cancel,
  output logic [TAG_W-1:0]   out_tag
);

  logic [NUM_RULES-1:0] hit, grant;
  logic                 hit_any;
  verdict_e             verdict;
  logic                 frees;
  logic [ERR_W-1:0]     err_d;
  logic                 fwd_d, cancel_d;

  cplchk_rules #(
    .RID_W(RID_W), .TAG_W(TAG_W), .TC_W(TC_W), .ATTR_W(ATTR_W),
    .LEN_W(LEN_W), .BCNT_W(BCNT_W), .LADDR_W(LADDR_W), .IO_BCNT(IO_BCNT)
  ) u_rules (
    .cpl_type   (cpl_type),
    .cpl_status (cpl_status),
    .cpl_req_id (cpl_req_id),
    .cpl_tag    (cpl_tag),
    .cpl_tc     (cpl_tc),
    .cpl_attr   (cpl_attr),
    .cpl_len    (cpl_len),
    .cpl_bcnt   (cpl_bcnt),
    .cpl_laddr  (cpl_laddr),
    .ent_valid  (ent_valid),
    .ent_kind   (ent_kind),
    .ent_req_id (ent_req_id),
    .ent_tag    (ent_tag),
    .ent_len    (ent_len),
    .ent_bcnt   (ent_bcnt),
    .ent_laddr  (ent_laddr),
    .relax_crs  (relax_crs),
    .skip_bcnt  (skip_bcnt),
    .skip_laddr (skip_laddr),
    .hit        (hit)
  );

  cplchk_arbiter #(.N(NUM_RULES)) u_arb (
    .req   (hit),
    .grant (grant),
    .any   (hit_any)
  );

  always_comb begin
    verdict = VD_GOOD;
    frees   = !hit_any;
    for (int i = 0; i < NUM_RULES; i++) begin
      if (grant[i]) begin
        verdict = rule_verdict(i);
        frees   = rule_frees(i);
      end
    end
    err_d    = (verdict == VD_GOOD) ? '0 : (ERR_W'(1) << verdict);
    fwd_d    = (verdict == VD_GOOD) || (verdict == VD_RDFAIL) ||
               (verdict == VD_WRFAIL);
    cancel_d = (verdict == VD_MALF) || (verdict == VD_RETRY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_err     <= '0;
      out_forward <= 1'b0;
      out_free    <= 1'b0;
      out_cancel  <= 1'b0;
      out_tag     <= '0;
    end else begin
      out_valid   <= in_valid;
      out_err     <= in_valid ? err_d : '0;
      out_forward <= in_valid && fwd_d;
      out_free    <= in_valid && frees;
      out_cancel  <= in_valid && cancel_d;
      out_tag     <= in_valid ? cpl_tag : '0;
    end
  end

endmodule

// File: rtl/cmpl_hdr_checker_sva.sv
module cmpl_hdr_checker_sva #(
  parameter int TAG_W = 8,
  parameter int ERR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       cpl_type,
  input logic [TAG_W-1:0] cpl_tag,
  input logic             ent_valid,
  input logic             out_valid,
  input logic [ERR_W-1:0] out_err,
  input logic             out_forward,
  input logic             out_free,
  input logic             out_cancel,
  input logic [TAG_W-1:0] out_tag
);

  p_verdict_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_quiet_after_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_forward && !out_free && !out_cancel &&
                   out_err == '0));

  p_tag_echo_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_tag == $past(cpl_tag)));

  p_unsol_dropped_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (!ent_valid || cpl_type[1])) |=>
      (out_err == ERR_W'(8) && !out_forward && !out_free && !out_cancel));

  p_single_error_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_err));

  p_forward_rule_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_forward == (out_err[3:1] == 3'b000)));

  p_cancel_rule_r11: assert property (@(posedge clk) disable iff (rst)
    out_cancel |-> (out_err[1] || out_err[2]));

  p_free_implies_fwd_r10: assert property (@(posedge clk) disable iff (rst)
    out_free |-> out_forward);

endmodule

bind cmpl_hdr_checker cmpl_hdr_checker_sva #(.TAG_W(TAG_W), .ERR_W(6)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .cpl_type    (cpl_type),
  .cpl_tag     (cpl_tag),
  .ent_valid   (ent_valid),
  .out_valid   (out_valid),
  .out_err     (out_err),
  .out_forward (out_forward),
  .out_free    (out_free),
  .out_cancel  (out_cancel),
  .out_tag     (out_tag)
);

// File: tb/cmpl_hdr_checker_bench.sv
module cmpl_hdr_checker_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  cpl_type = '0;
  logic [2:0]  cpl_status = '0;
  logic [15:0] cpl_req_id = '0;
  logic [7:0]  cpl_tag = '0;
  logic [2:0]  cpl_tc = '0;
  logic [1:0]  cpl_attr = '0;
  logic [9:0]  cpl_len = '0;
  logic [11:0] cpl_bcnt = '0;
  logic [6:0]  cpl_laddr = '0;
  logic        ent_valid = 1'b0;
  logic [2:0]  ent_kind = '0;
  logic [15:0] ent_req_id = '0;
  logic [7:0]  ent_tag = '0;
  logic [9:0]  ent_len = '0;
  logic [11:0] ent_bcnt = '0;
  logic [6:0]  ent_laddr = '0;
  logic        relax_crs = 1'b0;
  logic        skip_bcnt = 1'b0;
  logic        skip_laddr = 1'b0;
  logic        out_valid;
  logic [5:0]  out_err;
  logic        out_forward, out_free, out_cancel;
  logic [7:0]  out_tag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cmpl_hdr_checker u_cmpl_hdr_checker (.*);

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected result computed straight from the requirement text.
  logic [5:0] e_err;
  logic       e_free;
  string      e_req;

  task automatic model();
    bit rd, wr, cfg, iocfg, mrd, dat, urr;
    rd    = (ent_kind == 0) || (ent_kind == 2) || (ent_kind == 4);
    wr    = (ent_kind == 1) || (ent_kind == 3) || (ent_kind == 5);
    cfg   = (ent_kind == 4) || (ent_kind == 5);
    iocfg = (ent_kind >= 2) && (ent_kind <= 5);
    mrd   = (ent_kind == 0);
    dat   = cpl_type[0];
    urr   = (cpl_status != 0) && (cpl_status != 2) && (cpl_status != 4);
    e_free = 0;
    if (!ent_valid || cpl_req_id != ent_req_id || cpl_tag != ent_tag || cpl_type[1]) begin
      e_err = 6'd8; e_req = "R2";
    end else if (dat && cpl_status != 0 && cpl_status != 2) begin
      e_err = 6'd4; e_req = "R3";
    end else if (!relax_crs && cpl_status == 2 && !cfg) begin
      e_err = 6'd4; e_req = "R7";
    end else if (dat && wr) begin
      e_err = 6'd4; e_req = "R3";
    end else if (!dat && cpl_status == 0 && rd) begin
      e_err = 6'd4; e_req = "R3";
    end else if (cpl_tc != 0 || cpl_attr != 0 || (dat && cpl_len != ent_len)) begin
      e_err = 6'd4; e_req = "R4";
    end else if (!skip_bcnt && ((iocfg && cpl_bcnt != 4) || (mrd && cpl_bcnt != ent_bcnt))) begin
      e_err = 6'd4; e_req = "R5";
    end else if (!skip_laddr && ((iocfg && cpl_laddr != 0) || (mrd && cpl_laddr != ent_laddr))) begin
      e_err = 6'd4; e_req = "R6";
    end else if (cpl_status == 2 && cfg) begin
      e_err = 6'd2; e_req = "R7";
    end else if (relax_crs && cpl_status != 0 && (rd || wr)) begin
      e_err = rd ? 6'd16 : 6'd32; e_free = 1; e_req = "R9";
    end else if (cpl_status == 4 && rd) begin
      e_err = 6'd16; e_req = "R8";
    end else if ((cpl_status == 4 || urr) && iocfg && wr) begin
      e_err = 6'd32; e_req = "R8";
    end else if (urr && rd) begin
      e_err = 6'd16; e_req = "R8";
    end else begin
      e_err = 6'd0; e_free = 1; e_req = "R10";
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset valid", out_valid, 0);
    check("R1", "reset err", out_err, 0);
    check("R1", "reset fwd/free/cancel", {out_forward, out_free, out_cancel}, 0);
    @(negedge clk) rst = 1'b0;

    for (int kind = 0; kind < 6; kind++)
      for (int ty = 0; ty < 4; ty++)
        for (int st = 0; st < 8; st++)
          for (int ctl = 0; ctl < 8; ctl++)
            for (int var_i = 0; var_i < 9; var_i++) begin
              @(negedge clk);
              n++;
              in_valid   = 1'b1;
              ent_kind   = 3'(kind);
              cpl_type   = 2'(ty);
              cpl_status = 3'(st);
              {relax_crs, skip_bcnt, skip_laddr} = 3'(ctl);
              ent_valid  = 1'b1;
              ent_req_id = 16'h1234 ^ 16'(n);
              cpl_req_id = ent_req_id;
              ent_tag    = 8'(n * 7);
              cpl_tag    = ent_tag;
              cpl_tc     = 3'd0;
              cpl_attr   = 2'd0;
              ent_len    = 10'd4;
              cpl_len    = 10'd4;
              ent_bcnt   = 12'd13;
              ent_laddr  = 7'h25;
              cpl_bcnt   = (kind == 0) ? 12'd13 : 12'd4;
              cpl_laddr  = (kind == 0) ? 7'h25 : 7'h00;
              case (var_i)
                1: ent_valid  = 1'b0;
                2: cpl_req_id = cpl_req_id ^ 16'h0100;
                3: cpl_tag    = cpl_tag ^ 8'h80;
                4: cpl_tc     = 3'd1;
                5: cpl_attr   = 2'd2;
                6: cpl_len    = 10'd5;
                7: cpl_bcnt   = cpl_bcnt + 12'd1;
                8: cpl_laddr  = cpl_laddr ^ 7'h01;
                default: ;
              endcase
              model();
              @(posedge clk);
              #1;
              check("R1", "valid", out_valid, 1);
              check("R1", "tag", out_tag, cpl_tag);
              check(e_req, "err", out_err, e_err);
              check("R12", "one error bit", ($countones(out_err) <= 1), 1);
              check("R11", "forward", out_forward,
                    (e_err == 0 || e_err == 16 || e_err == 32));
              check("R11", "cancel", out_cancel, (e_err == 2 || e_err == 4));
              check("R10", "free", out_free, e_free);
            end

    @(negedge clk) in_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R1", "idle valid", out_valid, 0);
    check("R1", "idle outputs", {out_err, out_forward, out_free, out_cancel}, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule